// File: doc/BRIEF.md
# AHB-Lite Register Slave with Fault Response

This block is a small AHB-Lite register-file slave that checks every transfer aimed at it before it touches any state. A valid access completes in its single data-phase cycle with an OKAY response. An access that the slave refuses gets the protocol's two-cycle ERROR response. In the first cycle the slave holds the bus with HREADYOUT low and signals ERROR. In the second cycle it keeps ERROR and releases the bus. The master thus has one cycle in which to withdraw the address phase it has already issued.

The slave refuses an access for any of four reasons: the address falls in an unmapped hole, the transfer writes the read-only status word, the access is made in user mode, or the transfer is not a full word. The checks are combinational over the control that the slave latched during the address phase. Every register update and every read side effect is gated by the result of those checks, so a refused access leaves the slave exactly as it was. The map holds two read-write control words, a read-only status word, a flag word that is set by one alias and cleared by write-one on another, and a small push/pop queue.

Top module: `ahbl_err_slave`

## Requirements
- R1: The response output carries only two codes: 0 means OKAY and 1 means ERROR. HREADYOUT goes low only in the first cycle of an ERROR response, so valid accesses never see wait states.
- R2: A valid access completes in one data-phase cycle with readyout_o=1 and resp_o=0. A valid access is NONSEQ or SEQ, has size 3'b010, has prot_i[1]=1 and targets a mapped word. After reset the outputs are readyout_o=1, resp_o=0 and rdata_o=0.
- R3: A faulted access produces resp_o=1 with readyout_o=0 in its first data-phase cycle. In the next cycle resp_o=1 with readyout_o=1. The slave then returns to OKAY unless a new faulted transfer was captured.
- R4: rdata_o is zero in both cycles of an ERROR response.
- R5: Byte offsets 0x18 and 0x1C, and any address with a bit set above bit 4, are holes. Reads and writes to them fault.
- R6: The status word at 0x08 reads with OKAY. It returns empty in bit 0, full in bit 1 and the queue occupancy in bits [15:8]. A write to it faults and changes nothing.
- R7: An access with prot_i[1]=0 (user mode) faults and changes no state.
- R8: An access with any size other than 3'b010 faults and changes no state.
- R9: The control words at 0x00 and 0x04 read back the last value written to them. A faulted write leaves them unchanged.
- R10: A write to 0x10 ORs wdata_i[7:0] into the 8-bit flag word. A write to 0x0C clears the flag bits where wdata_i has a 1. Reads of either offset return the flags in bits [7:0]. A faulted write leaves the flags unchanged.
- R11: A write to 0x14 pushes the word into a 4-entry queue, and the word is dropped when the queue is full. A read of 0x14 pops the oldest entry, or returns 0 when the queue is empty. A faulted read pops nothing.
- R12: The address phase is captured only when sel_i=1, ready_i=1 and trans_i is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) transfers get a zero-wait OKAY and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select |
| addr_i | input | ADDR_W | Byte address |
| trans_i | input | 2 | Transfer type |
| write_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 3 | Transfer size |
| prot_i | input | 4 | Protection attributes; bit 1 marks privileged |
| wdata_i | input | 32 | Write data, valid in the data phase |
| ready_i | input | 1 | Bus-wide ready, qualifies the address phase |
| readyout_o | output | 1 | Slave ready |
| resp_o | output | 1 | Response: 0 OKAY, 1 ERROR |
| rdata_o | output | 32 | Read data |

## Verification
The assertions check the shape of the response on every cycle. Wait states occur only with ERROR. A held ERROR cycle is always followed by a released ERROR cycle. A released ERROR always had a held one before it. Read data is zero throughout an ERROR. A cycle with nothing captured answers OKAY with no wait. Whether a refused access really left the control words, the flags and the queue untouched can only be shown by the bench's scenarios. They read that state back through normal accesses after each fault and compare it with an independent model of the map.

// File: rtl/ahbl_err_pkg.sv
package ahbl_err_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  // word index map, byte offset = index * 4
  localparam logic [IDX_W-1:0] IDX_CTRL0     = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CTRL1     = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STATUS    = 3'd2;
  localparam logic [IDX_W-1:0] IDX_FLAG_CLR  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_FLAG_SET  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_QUEUE     = 3'd5;
  localparam logic [IDX_W-1:0] IDX_FIRST_GAP = 3'd6;
  localparam int unsigned      NUM_CTRL      = 2;

  localparam logic [2:0] SIZE_WORD = 3'b010;
  localparam int unsigned PRIV_BIT = 1;

  localparam int unsigned ST_EMPTY_BIT = 0;
  localparam int unsigned ST_FULL_BIT  = 1;
  localparam int unsigned ST_CNT_LSB   = 8;
  localparam int unsigned ST_CNT_W     = 8;

  typedef enum logic {
    RSP_OKAY  = 1'b0,
    RSP_ERROR = 1'b1
  } rsp_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_TAIL = 1'b1
  } seq_e;

  typedef struct packed {
    logic             write;
    logic [2:0]       size;
    logic             priv;
    logic [IDX_W-1:0] idx;
    logic             off_map;
  } ctx_t;

endpackage

// File: rtl/ahbl_err_capture.sv
module ahbl_err_capture
  import ahbl_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              ready_i,
  input  logic [1:0]        trans_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [3:0]        prot_i,
  output logic              valid_o,
  output ctx_t              ctx_o
);

  localparam int unsigned MAP_MSB = IDX_W + 1;

  logic take;
  logic off_map;
  ctx_t ctx_d;
  logic unused_bits;

  // NONSEQ and SEQ both have bit 1 set
  assign take = sel_i && trans_i[1];

  generate
    if (ADDR_W > MAP_MSB + 1) begin : g_wide
      assign off_map = |addr_i[ADDR_W-1:MAP_MSB+1];
    end else begin : g_narrow
      assign off_map = 1'b0;
    end
  endgenerate

  assign unused_bits = ^{addr_i[1:0], trans_i[0], prot_i[3:2], prot_i[0]};

  always_comb begin
    ctx_d         = '0;
    ctx_d.write   = write_i;
    ctx_d.size    = size_i;
    ctx_d.priv    = prot_i[PRIV_BIT];
    ctx_d.idx     = addr_i[MAP_MSB:2];
    ctx_d.off_map = off_map;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ctx_o   <= '0;
    end else if (ready_i) begin
      valid_o <= take;
      if (take) ctx_o <= ctx_d;
    end
  end

endmodule

// File: rtl/ahbl_err_check.sv
module ahbl_err_check
  import ahbl_err_pkg::*;
(
  input  logic valid_i,
  input  ctx_t ctx_i,
  output logic fault_o
);

  logic gap_hit;
  logic ro_write;
  logic user_mode;
  logic bad_size;

  assign gap_hit   = ctx_i.off_map || (ctx_i.idx >= IDX_FIRST_GAP);
  assign ro_write  = ctx_i.write && (ctx_i.idx == IDX_STATUS);
  assign user_mode = !ctx_i.priv;
  assign bad_size  = ctx_i.size != SIZE_WORD;

  assign fault_o = valid_i && (gap_hit || ro_write || user_mode || bad_size);

endmodule

// File: rtl/ahbl_err_seq.sv
module ahbl_err_seq
  import ahbl_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic fault_i,
  output logic resp_o,
  output logic readyout_o,
  output logic commit_o
);

  seq_e state_q, state_d;
  rsp_e rsp;

  always_comb begin
    state_d    = state_q;
    rsp        = RSP_OKAY;
    readyout_o = 1'b1;
    commit_o   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (fault_i) begin
          rsp        = RSP_ERROR;
          readyout_o = 1'b0;
          state_d    = SEQ_TAIL;
        end else begin
          commit_o = valid_i;
        end
      end
      SEQ_TAIL: begin
        // response must stay ERROR while the bus is released
        rsp     = RSP_ERROR;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign resp_o = rsp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/ahbl_err_regs.sv
module ahbl_err_regs
  import ahbl_err_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH = 4,
  parameter int unsigned FLAG_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              write_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(QUEUE_DEPTH + 1);

  logic              wr_en, rd_en;
  logic [DATA_W-1:0] ctrl_q [NUM_CTRL];
  logic [FLAG_W-1:0] flags_q;
  logic [DATA_W-1:0] mem_q  [QUEUE_DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              q_full, q_empty, push, pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_en   = commit_i && write_i;
  assign rd_en   = commit_i && !write_i;
  assign q_full  = cnt_q == CNT_W'(QUEUE_DEPTH);
  assign q_empty = cnt_q == '0;
  assign push    = wr_en && (idx_i == IDX_QUEUE) && !q_full;
  assign pop     = rd_en && (idx_i == IDX_QUEUE) && !q_empty;

  generate
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                ctrl_q[g] <= '0;
        else if (wr_en && idx_i == IDX_W'(g))       ctrl_q[g] <= wdata_i;
      end
    end

    for (genvar e = 0; e < QUEUE_DEPTH; e++) begin : g_slot
      always_ff @(posedge clk_i) begin
        if (push && wr_ptr_q == PTR_W'(e)) mem_q[e] <= wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (wr_en && idx_i == IDX_FLAG_CLR) begin
      flags_q <= flags_q & ~wdata_i[FLAG_W-1:0];
    end else if (wr_en && idx_i == IDX_FLAG_SET) begin
      flags_q <= flags_q | wdata_i[FLAG_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (idx_i)
        IDX_CTRL0: rdata_o = ctrl_q[0];
        IDX_CTRL1: rdata_o = ctrl_q[1];
        IDX_STATUS: begin
          rdata_o[ST_EMPTY_BIT]              = q_empty;
          rdata_o[ST_FULL_BIT]               = q_full;
          rdata_o[ST_CNT_LSB +: ST_CNT_W]    = ST_CNT_W'(cnt_q);
        end
        IDX_FLAG_CLR, IDX_FLAG_SET: rdata_o[FLAG_W-1:0] = flags_q;
        IDX_QUEUE: rdata_o = q_empty ? '0 : mem_q[rd_ptr_q];
        default:   rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/ahbl_err_slave.sv
module ahbl_err_slave
  import ahbl_err_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned QUEUE_DEPTH = 4,
  parameter int unsigned FLAG_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [3:0]        prot_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic              readyout_o,
  output logic              resp_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic valid;
  ctx_t ctx;
  logic fault;
  logic commit;

  ahbl_err_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .ready_i (ready_i),
    .trans_i (trans_i),
    .addr_i  (addr_i),
    .write_i (write_i),
    .size_i  (size_i),
    .prot_i  (prot_i),
    .valid_o (valid),
    .ctx_o   (ctx)
  );

  ahbl_err_check u_check (
    .valid_i (valid),
    .ctx_i   (ctx),
    .fault_o (fault)
  );

  ahbl_err_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid),
    .fault_i    (fault),
    .resp_o     (resp_o),
    .readyout_o (readyout_o),
    .commit_o   (commit)
  );

  ahbl_err_regs #(
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .FLAG_W      (FLAG_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .write_i  (ctx.write),
    .idx_i    (ctx.idx),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o)
  );

endmodule

// File: rtl/ahbl_err_sva.sv
module ahbl_err_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sel_i,
  input logic [1:0]  trans_i,
  input logic        ready_i,
  input logic        readyout_i,
  input logic        resp_i,
  input logic [31:0] rdata_i
);

  p_wait_only_err_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !readyout_i |-> resp_i);

  p_err_second_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_i && !readyout_i) |=> (resp_i && readyout_i));

  p_err_origin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_i && readyout_i) |-> $past(resp_i && !readyout_i));

  p_err_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_i && readyout_i) |=> !(resp_i && readyout_i));

  p_err_rdata_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_i |-> (rdata_i == '0));

  p_idle_okay_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && readyout_i && !(sel_i && trans_i[1])) |=> (readyout_i && !resp_i));

endmodule

bind ahbl_err_slave ahbl_err_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .trans_i    (trans_i),
  .ready_i    (ready_i),
  .readyout_i (readyout_o),
  .resp_i     (resp_o),
  .rdata_i    (rdata_o)
);

// File: tb/ahbl_err_slave_tb.sv
module ahbl_err_slave_tb;

  localparam logic [3:0] PRIV = 4'b0011;
  localparam logic [3:0] USER = 4'b0001;
  localparam logic [2:0] WORD = 3'b010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  trans = 2'b00;
  logic        write = 1'b0;
  logic [2:0]  size = WORD;
  logic [3:0]  prot = PRIV;
  logic [31:0] wdata = '0;
  logic        ready;
  logic        readyout;
  logic        resp;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;
  assign ready = readyout;

  ahbl_err_slave u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sel_i      (sel),
    .addr_i     (addr),
    .trans_i    (trans),
    .write_i    (write),
    .size_i     (size),
    .prot_i     (prot),
    .wdata_i    (wdata),
    .ready_i    (ready),
    .readyout_o (readyout),
    .resp_o     (resp),
    .rdata_o    (rdata)
  );

  typedef struct packed {
    logic        err;
    logic        chk;
    logic [31:0] rd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // reference model of the map
  logic [31:0] m_ctrl [2];
  logic [7:0]  m_flags;
  logic [31:0] m_fifo[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  logic dp = 1'b0;
  bit   saw_low = 1'b0;

  always @(posedge clk) begin
    if (!rst_n)        dp <= 1'b0;
    else if (readyout) dp <= sel && trans[1];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (dp) begin
        if (!readyout) begin
          chk(resp == 1'b1, "R3", "first error cycle resp", {31'b0, resp}, 32'd1);
          chk(rdata == '0, "R4", "rdata in first error cycle", rdata, 32'd0);
          chk(exp_q.size() > 0 && exp_q[0].err, "R1", "wait state on valid access",
              {31'b0, readyout}, 32'd1);
          saw_low = 1'b1;
        end else if (exp_q.size() > 0) begin
          exp_t  it;
          string tg;
          it = exp_q.pop_front();
          tg = tag_q.pop_front();
          chk(resp == it.err, tg, "response", {31'b0, resp}, {31'b0, it.err});
          if (it.err) begin
            chk(saw_low, "R3", "error completed without held cycle", {31'b0, saw_low}, 32'd1);
            chk(rdata == '0, "R4", "rdata in second error cycle", rdata, 32'd0);
          end else begin
            chk(!saw_low, "R2", "valid access had wait state", {31'b0, saw_low}, 32'd0);
            if (it.chk) chk(rdata == it.rd, tg, "read data", rdata, it.rd);
          end
          saw_low = 1'b0;
        end
      end else begin
        chk(readyout && !resp, "R12", "no transfer yet not OKAY", {30'b0, readyout, resp}, 32'd2);
      end
    end
  end

  task automatic access(input logic [11:0] a, input logic wr, input logic [2:0] sz,
                        input logic [3:0] pr, input logic [31:0] wd, input string tag);
    logic [2:0]  idx;
    logic        flt;
    exp_t        it;
    idx = a[4:2];
    flt = (a[11:5] != '0) || (idx >= 3'd6) || (wr && idx == 3'd2) || !pr[1] || (sz != WORD);
    it.err = flt;
    it.chk = !wr && !flt;
    it.rd  = '0;
    if (!flt) begin
      if (wr) begin
        case (idx)
          3'd0, 3'd1: m_ctrl[idx[0]] = wd;
          3'd3: m_flags = m_flags & ~wd[7:0];
          3'd4: m_flags = m_flags | wd[7:0];
          3'd5: if (m_fifo.size() < 4) m_fifo.push_back(wd);
          default: ;
        endcase
      end else begin
        case (idx)
          3'd0, 3'd1: it.rd = m_ctrl[idx[0]];
          3'd2: it.rd = {16'h0, 8'(m_fifo.size()), 6'b0, m_fifo.size() == 4, m_fifo.size() == 0};
          3'd3, 3'd4: it.rd = {24'h0, m_flags};
          3'd5: it.rd = (m_fifo.size() == 0) ? 32'h0 : m_fifo.pop_front();
          default: ;
        endcase
      end
    end
    exp_q.push_back(it);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    sel = 1'b1; addr = a; trans = 2'b10; write = wr; size = sz; prot = pr;
    @(posedge clk); #1;
    // cancel any follow-on: idle while in data phase
    sel = 1'b0; trans = 2'b00; wdata = wd;
    @(negedge clk);
    while (!readyout) @(negedge clk);
  endtask

  task automatic idle_write(input logic [1:0] tv);
    @(posedge clk); #1;
    sel = 1'b1; addr = 12'h000; trans = tv; write = 1'b1; size = WORD; prot = PRIV;
    @(posedge clk); #1;
    sel = 1'b0; trans = 2'b00; wdata = 32'hDEAD_0000;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_ctrl[0] = '0;
    m_ctrl[1] = '0;
    m_flags   = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(readyout == 1'b1, "R2", "reset readyout", {31'b0, readyout}, 32'd1);
    chk(resp == 1'b0, "R2", "reset resp", {31'b0, resp}, 32'd0);
    chk(rdata == '0, "R2", "reset rdata", rdata, 32'd0);
    rst_n = 1'b1;

    // R9 control words
    access(12'h000, 1, WORD, PRIV, 32'hA5A5_0001, "R9");
    access(12'h004, 1, WORD, PRIV, 32'h0000_BEEF, "R9");
    access(12'h000, 0, WORD, PRIV, 32'h0, "R9");
    access(12'h004, 0, WORD, PRIV, 32'h0, "R9");
    // R7 user-mode write refused, value kept
    access(12'h000, 1, WORD, USER, 32'h1111_2222, "R7");
    access(12'h000, 0, WORD, PRIV, 32'h0, "R7");
    access(12'h004, 0, WORD, USER, 32'h0, "R7");
    // R8 sub-word sizes refused
    access(12'h004, 1, 3'b000, PRIV, 32'h3333_4444, "R8");
    access(12'h004, 1, 3'b001, PRIV, 32'h5555_6666, "R8");
    access(12'h004, 0, 3'b001, PRIV, 32'h0, "R8");
    access(12'h004, 0, WORD, PRIV, 32'h0, "R8");
    // R5 holes
    access(12'h018, 0, WORD, PRIV, 32'h0, "R5");
    access(12'h01C, 1, WORD, PRIV, 32'h7777_7777, "R5");
    access(12'h040, 1, WORD, PRIV, 32'h8888_8888, "R5");
    access(12'h040, 0, WORD, PRIV, 32'h0, "R5");
    access(12'h000, 0, WORD, PRIV, 32'h0, "R5");
    // R6 status
    access(12'h008, 0, WORD, PRIV, 32'h0, "R6");
    access(12'h008, 1, WORD, PRIV, 32'hFFFF_FFFF, "R6");
    access(12'h008, 0, WORD, PRIV, 32'h0, "R6");
    // R10 flags
    access(12'h010, 1, WORD, PRIV, 32'h0000_000F, "R10");
    access(12'h00C, 1, WORD, PRIV, 32'h0000_0005, "R10");
    access(12'h00C, 0, WORD, PRIV, 32'h0, "R10");
    access(12'h00C, 1, WORD, USER, 32'h0000_00FF, "R10");
    access(12'h010, 1, 3'b000, PRIV, 32'h0000_00F0, "R10");
    access(12'h010, 0, WORD, PRIV, 32'h0, "R10");
    // R11 queue
    for (int i = 0; i < 5; i++)
      access(12'h014, 1, WORD, PRIV, 32'hC0DE_0000 + i, "R11");
    access(12'h008, 0, WORD, PRIV, 32'h0, "R11");
    access(12'h014, 0, WORD, USER, 32'h0, "R11");
    access(12'h014, 0, 3'b010, 4'b0000, 32'h0, "R11");
    access(12'h008, 0, WORD, PRIV, 32'h0, "R11");
    for (int i = 0; i < 5; i++)
      access(12'h014, 0, WORD, PRIV, 32'h0, "R11");
    access(12'h008, 0, WORD, PRIV, 32'h0, "R11");
    // R12 idle and busy have no effect
    idle_write(2'b00);
    idle_write(2'b01);
    access(12'h000, 0, WORD, PRIV, 32'h0, "R12");
    // R3 back-to-back: fault then valid, and fault then fault
    access(12'h01C, 0, WORD, PRIV, 32'h0, "R3");
    access(12'h004, 0, WORD, PRIV, 32'h0, "R3");
    access(12'h008, 1, WORD, PRIV, 32'h1, "R3");
    access(12'h018, 1, WORD, USER, 32'h2, "R3");
    access(12'h008, 0, WORD, PRIV, 32'h0, "R3");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule